// File: doc/BRIEF.md
# Dual-Mode SPI Register Port

This block is an SPI slave that lets an external master read and write a bank of thirty-two 8-bit registers. The SPI pins (clock, active-low select, and the two data lines) are sampled by a faster system clock. Each pin passes through a synchronizer chain and an edge detector. All shifting, decoding and register access happen in the system clock domain. Each data line has a separate output value and output enable, so that the pad or a higher level of the chip builds the tri-state buffer.

Every access begins with one command byte. The command byte holds a register address and a direction flag. Any number of data bytes may follow while select stays low. The register address advances after each data byte and wraps around the bank.

A configuration bit selects the line usage:
- **Full-duplex mode:** MOSI and MISO are separate lines. MISO returns an 8-bit status vector while the command byte arrives. After the command byte, MISO carries register data for a read, or zeros for a write.
- **Half-duplex mode:** MISO is never driven. A single data line carries both directions, and the slave drives MOSI back to the master during read data. Status can still be fetched as a normal register.

Top module: `spi_dual_regport`

## Requirements
- R1: Register address 0 is the configuration register, and its bit 0 selects the mode: 1 for full-duplex, 0 for half-duplex. The register resets to 0. The mode is captured when select falls, so a write to the mode bit takes effect from the next access.
- R2: While select is high, MISO and MOSI output enables are both low. Both enables drop once select returns high.
- R3: In full-duplex mode, the falling edge of select turns the MISO enable on. MISO then presents the most significant status bit before the first SCLK rising edge.
- R4: Incoming bits are taken on rising SCLK edges and outgoing bits change on falling SCLK edges. Every byte moves most significant bit first.
- R5: In full-duplex mode, the 8 bits shifted out on MISO during the command byte equal the status input, sampled when select falls.
- R6: While select stays low, the access continues byte by byte. The register address increases by one after every data byte and wraps from 31 to 0.
- R7: In a full-duplex read, MISO carries the addressed register contents after the command byte. Data arriving on MOSI meanwhile changes no register.
- R8: In a full-duplex write, MISO outputs zero, with its enable high, during every data byte. Each received byte is stored at the current address.
- R9: In half-duplex mode, the MISO enable stays low for the whole access. Register address 1 reads the live status input, and writes to address 1 have no effect.
- R10: In the command byte, bits 7 down to 3 form the register address and bit 1 is the direction (1 write, 0 read). Bits 2 and 0 have no effect.
- R11: In a half-duplex read, the slave enables its MOSI output from the SCLK falling edge after the eighth command bit until select rises. It never enables MOSI during the command byte, during a write, or in full-duplex mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from the master, idle low |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_mosi_i | input | 1 | Master-to-slave data line, as seen at the pad |
| spi_mosi_o | output | 1 | Value driven onto the shared data line in half-duplex reads |
| spi_mosi_oe | output | 1 | Output enable for the shared data line |
| spi_miso_o | output | 1 | Slave-to-master data value |
| spi_miso_oe | output | 1 | Output enable for MISO |
| status_in | input | 8 | Status vector returned during full-duplex commands and at address 1 |

## Verification
The bench runs bursts that cross the top of the bank. A design that failed to wrap would write beyond address 31 and would not reach the configuration register at 0. Data and status patterns are asymmetric under bit reversal, so an LSB-first shifter shows up as corrupted bytes. Select-to-first-edge timing is checked, so a slave that loaded status late would return a shifted status byte. The bench also drives all-ones junk on MOSI during full-duplex reads and then reads the registers back, exposing a design that stored bytes while sending. Mode switches in both directions confirm that MISO is never enabled in half-duplex mode and that the shared line is driven back only after the command byte.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 5;
  localparam int BIT_CW  = $clog2(BYTE_W);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              unused_hi;
    logic              write;
    logic              unused_lo;
  } cmd_t;
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{INIT}};
      prev  <= INIT;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regport_pkg::*;
#(
  parameter int CFG_ADDR  = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] status_in,
  output logic [BYTE_W-1:0] rdata,
  output logic              fd_mode
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] cfg_q;

  // plain array, no reset: maps to distributed or block RAM
  always_ff @(posedge clk) begin
    if (we && addr != ADDR_W'(STAT_ADDR))
      mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (we && addr == ADDR_W'(CFG_ADDR))
      cfg_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (addr == ADDR_W'(CFG_ADDR))
      rdata <= cfg_q;
    else if (addr == ADDR_W'(STAT_ADDR))
      rdata <= status_in;
    else
      rdata <= mem[addr];
  end

  assign fd_mode = cfg_q[0];

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == ADDR_W'(CFG_ADDR)) |=> $stable(cfg_q)); // R1
endmodule

// File: rtl/spi_xfer_core.sv
module spi_xfer_core
  import spi_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              ss_lvl,
  input  logic              ss_fall,
  input  logic              mosi_lvl,
  input  logic [BYTE_W-1:0] status_in,
  input  logic              fd_mode,
  input  logic [BYTE_W-1:0] bank_rdata,
  output logic [ADDR_W-1:0] bank_addr,
  output logic              bank_we,
  output logic [BYTE_W-1:0] bank_wdata,
  output logic              miso_o,
  output logic              miso_oe,
  output logic              mosi_o,
  output logic              mosi_oe
);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BIT_CW-1:0] bit_q;
  logic [ADDR_W-1:0] addr_q;
  logic              in_cmd_q;
  logic              wr_q;
  logic              txn_fd_q;
  logic [BYTE_W-1:0] byte_in;
  cmd_t              cmd_now;

  assign byte_in    = {rx_q[BYTE_W-2:0], mosi_lvl};
  assign cmd_now    = cmd_t'(byte_in);
  assign bank_addr  = addr_q;
  assign bank_wdata = byte_in;
  assign bank_we    = !ss_lvl && sclk_rise && bit_q == LAST_BIT && !in_cmd_q && wr_q;
  assign miso_o     = tx_q[BYTE_W-1];
  assign mosi_o     = tx_q[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q     <= '0;
      tx_q     <= '0;
      bit_q    <= '0;
      addr_q   <= '0;
      in_cmd_q <= 1'b1;
      wr_q     <= 1'b0;
      txn_fd_q <= 1'b0;
      miso_oe  <= 1'b0;
      mosi_oe  <= 1'b0;
    end else if (ss_lvl) begin
      bit_q    <= '0;
      in_cmd_q <= 1'b1;
      tx_q     <= '0;
      miso_oe  <= 1'b0;
      mosi_oe  <= 1'b0;
    end else if (ss_fall) begin
      bit_q    <= '0;
      in_cmd_q <= 1'b1;
      txn_fd_q <= fd_mode;
      miso_oe  <= fd_mode;
      tx_q     <= fd_mode ? status_in : '0;
    end else begin
      if (sclk_rise) begin
        rx_q  <= byte_in;
        bit_q <= bit_q + 1'b1;
        if (bit_q == LAST_BIT) begin
          if (in_cmd_q) begin
            in_cmd_q <= 1'b0;
            addr_q   <= cmd_now.addr;
            wr_q     <= cmd_now.write;
          end else if (wr_q) begin
            addr_q <= addr_q + 1'b1;
          end
        end
      end
      if (sclk_fall) begin
        if (bit_q == '0 && !in_cmd_q) begin
          if (wr_q) begin
            tx_q <= '0;
          end else begin
            tx_q   <= bank_rdata;
            addr_q <= addr_q + 1'b1;
            if (!txn_fd_q) mosi_oe <= 1'b1;
          end
        end else begin
          tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  AST_MISO_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ss_lvl |=> !miso_oe); // R2
  AST_FD_CMD_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ($fell(ss_lvl) && fd_mode) |=> miso_oe); // R3
  AST_HD_NO_MISO: assert property (@(posedge clk) disable iff (rst)
    !txn_fd_q |-> !miso_oe); // R9
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({miso_oe, mosi_oe})); // R11
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!in_cmd_q && $past(!in_cmd_q) && addr_q != $past(addr_q))
      |-> addr_q == ADDR_W'($past(addr_q) + 1'b1)); // R6
endmodule

// File: rtl/spi_dual_regport.sv
module spi_dual_regport
  import spi_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CFG_ADDR    = 0,
  parameter int STAT_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_ss_n,
  input  logic              spi_mosi_i,
  output logic              spi_mosi_o,
  output logic              spi_mosi_oe,
  output logic              spi_miso_o,
  output logic              spi_miso_oe,
  input  logic [BYTE_W-1:0] status_in
);
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic ss_lvl, ss_rise, ss_fall;
  logic mosi_lvl, mosi_rise, mosi_fall;
  logic [ADDR_W-1:0] bank_addr;
  logic              bank_we;
  logic [BYTE_W-1:0] bank_wdata;
  logic [BYTE_W-1:0] bank_rdata;
  logic              fd_mode;

  spi_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sclk (
    .clk(clk), .rst(rst), .din(spi_sclk),
    .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));

  spi_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_ss (
    .clk(clk), .rst(rst), .din(spi_ss_n),
    .level(ss_lvl), .rise(ss_rise), .fall(ss_fall));

  spi_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_mosi (
    .clk(clk), .rst(rst), .din(spi_mosi_i),
    .level(mosi_lvl), .rise(mosi_rise), .fall(mosi_fall));

  spi_reg_bank #(.CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)) u_bank (
    .clk(clk), .rst(rst), .addr(bank_addr), .we(bank_we),
    .wdata(bank_wdata), .status_in(status_in),
    .rdata(bank_rdata), .fd_mode(fd_mode));

  spi_xfer_core u_core (
    .clk(clk), .rst(rst),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .ss_lvl(ss_lvl), .ss_fall(ss_fall), .mosi_lvl(mosi_lvl),
    .status_in(status_in), .fd_mode(fd_mode), .bank_rdata(bank_rdata),
    .bank_addr(bank_addr), .bank_we(bank_we), .bank_wdata(bank_wdata),
    .miso_o(spi_miso_o), .miso_oe(spi_miso_oe),
    .mosi_o(spi_mosi_o), .mosi_oe(spi_mosi_oe));

  AST_SS_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ss_lvl && $past(ss_lvl)) |-> !(spi_miso_oe || spi_mosi_oe)); // R2
endmodule

// File: tb/tb_spi_dual_regport.sv
module tb_spi_dual_regport;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic ss_n = 1'b1;
  logic mosi_i = 1'b0;
  logic [7:0] status = 8'h00;
  logic mosi_o, mosi_oe, miso_o, miso_oe;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [7:0] junk = 8'h00;
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];
  logic [7:0] cap_miso, cap_mosi, cmd_miso;
  bit cap_miso_all, cap_miso_any, cap_mosi_all, cap_mosi_any;
  bit cmd_miso_all, cmd_miso_any, cmd_mosi_any;
  bit dat_miso_all, dat_miso_any, dat_mosi_all, dat_mosi_any;

  always #2 clk = ~clk;

  spi_dual_regport dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_ss_n(ss_n),
    .spi_mosi_i(mosi_i), .spi_mosi_o(mosi_o), .spi_mosi_oe(mosi_oe),
    .spi_miso_o(miso_o), .spi_miso_oe(miso_oe), .status_in(status));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic shift_byte(input logic [7:0] val, input bit drive);
    cap_miso_all = 1; cap_miso_any = 0; cap_mosi_all = 1; cap_mosi_any = 0;
    for (int i = 7; i >= 0; i--) begin
      mosi_i = drive ? val[i] : junk[i];
      half_wait();
      cap_miso[i] = miso_o;
      cap_mosi[i] = mosi_o;
      cap_miso_all = cap_miso_all & miso_oe;
      cap_miso_any = cap_miso_any | miso_oe;
      cap_mosi_all = cap_mosi_all & mosi_oe;
      cap_mosi_any = cap_mosi_any | mosi_oe;
      sclk = 1'b1;
      half_wait();
      sclk = 1'b0;
    end
  endtask

  // one access: command then n data bytes; hd_rd takes data from the shared line
  task automatic access(input logic [7:0] cmd, input int n, input bit wr, input bit hd_rd);
    dat_miso_all = 1; dat_miso_any = 0; dat_mosi_all = 1; dat_mosi_any = 0;
    @(negedge clk);
    ss_n = 1'b0;
    shift_byte(cmd, 1'b1);
    cmd_miso = cap_miso; cmd_miso_all = cap_miso_all;
    cmd_miso_any = cap_miso_any; cmd_mosi_any = cap_mosi_any;
    for (int k = 0; k < n; k++) begin
      shift_byte(wbuf[k], wr);
      rbuf[k] = hd_rd ? cap_mosi : cap_miso;
      dat_miso_all = dat_miso_all & cap_miso_all;
      dat_miso_any = dat_miso_any | cap_miso_any;
      dat_mosi_all = dat_mosi_all & cap_mosi_all;
      dat_mosi_any = dat_mosi_any | cap_mosi_any;
    end
    half_wait();
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 enables released after select high", {miso_oe, mosi_oe}, 2'b00);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 reset miso_oe", miso_oe, 1'b0);
    check("R2 reset mosi_oe", mosi_oe, 1'b0);
  endtask

  task automatic t_hd_write_read();
    status = 8'hD2;
    wbuf[0] = 8'h3A; wbuf[1] = 8'hC1;
    access(8'h2A, 2, 1'b1, 1'b0);          // write addr 5, burst
    check("R1 default half-duplex: no MISO during access", cmd_miso_any | dat_miso_any, 1'b0);
    check("R11 no MOSI drive during write", cmd_mosi_any | dat_mosi_any, 1'b0);
    junk = 8'h00;
    access(8'h2D, 2, 1'b0, 1'b1);          // read addr 5, bits 2 and 0 set
    check("R10 ignored cmd bits, R4 first byte", rbuf[0], 8'h3A);
    check("R6 burst second byte", rbuf[1], 8'hC1);
    check("R11 MOSI not driven during command", cmd_mosi_any, 1'b0);
    check("R11 MOSI driven during read data", dat_mosi_all, 1'b1);
    check("R9 MISO off in half-duplex read", cmd_miso_any | dat_miso_any, 1'b0);
  endtask

  task automatic t_hd_status();
    status = 8'h96;
    access(8'h08, 1, 1'b0, 1'b1);
    check("R9 status register read", rbuf[0], 8'h96);
    wbuf[0] = 8'h00;
    access(8'h0A, 1, 1'b1, 1'b0);          // write to status address
    status = 8'h4E;
    access(8'h08, 1, 1'b0, 1'b1);
    check("R9 status write ignored, live value", rbuf[0], 8'h4E);
  endtask

  task automatic t_fd_burst();
    wbuf[0] = 8'h01;
    access(8'h02, 1, 1'b1, 1'b0);          // mode bit = full-duplex
    check("R1 mode change not applied within same access", dat_miso_any, 1'b0);
    status = 8'hD2;
    wbuf[0] = 8'h11; wbuf[1] = 8'h6C; wbuf[2] = 8'h01;
    access(8'hF2, 3, 1'b1, 1'b0);          // write 30,31, wrap to 0
    check("R3 MISO enabled from select", cmd_miso_all, 1'b1);
    check("R5 status shifted during command", cmd_miso, 8'hD2);
    check("R8 MISO zeros during write data", rbuf[0] | rbuf[1] | rbuf[2], 8'h00);
    check("R8 MISO enabled during write data", dat_miso_all, 1'b1);
    status = 8'h2B;
    junk = 8'hFF;
    access(8'hF5, 3, 1'b0, 1'b0);          // read from 30 with junk on MOSI
    check("R3 status MSB before first edge, R5 status", cmd_miso, 8'h2B);
    check("R7 read addr 30", rbuf[0], 8'h11);
    check("R6 read addr 31", rbuf[1], 8'h6C);
    check("R6 wrap to addr 0", rbuf[2], 8'h01);
    check("R11 no MOSI drive in full-duplex", cmd_mosi_any | dat_mosi_any, 1'b0);
    access(8'hF0, 2, 1'b0, 1'b0);
    check("R7 MOSI junk did not write addr 30", rbuf[0], 8'h11);
    check("R7 MOSI junk did not write addr 31", rbuf[1], 8'h6C);
  endtask

  task automatic t_back_to_hd();
    wbuf[0] = 8'h00;
    access(8'h02, 1, 1'b1, 1'b0);          // mode bit = half-duplex
    check("R1 full-duplex still active for this access", cmd_miso_all, 1'b1);
    junk = 8'h00;
    access(8'h28, 1, 1'b0, 1'b1);
    check("R1 half-duplex again: MISO off", cmd_miso_any | dat_miso_any, 1'b0);
    check("R1 half-duplex read on shared line", rbuf[0], 8'h3A);
  endtask

  initial begin
    t_reset();
    t_hd_write_read();
    t_hd_status();
    t_fd_burst();
    t_back_to_hd();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule